// File: doc/BRIEF.md
# Block-Index Event Scheduler

This block follows the stream of block indices produced by an upstream block source and issues a one-cycle trigger at the start of one block chosen by software. Each block begins with a start-of-block strobe qualified by a valid flag and carries a 64-bit running index. Software picks the block index at which something should start, typically a signal generator. It writes that index as two 32-bit register words. The scheduler then fires exactly once, in the same cycle as the start strobe of the matching block.

Software also reads the most recent block index through the same register window, so it can schedule a few blocks ahead of the stream. A schedule whose block has already begun, or which the stream skips over, is never honoured late. Instead a sticky status flag records the miss until software clears it. A read of the low index word freezes the high word, so a two-word read is always coherent.

Top module: `blk_evt_sched`

## Requirements
- R1: After reset the trigger is low, the read data is zero and the status word (bit 0 missed flag, bit 1 armed flag) reads zero.
- R2: A read of address 0 returns, on the read data one cycle later, the low 32 bits of the index carried by the most recent block start that had valid high.
- R3: A read of address 1 returns the high 32 bits of the current index as they were at the most recent read of address 0, even if later blocks have changed the live index.
- R4: A write to address 0 loads the low 32 bits of the scheduled index without arming. A write to address 1 loads the high 32 bits and arms the schedule, which shows as status bit 1.
- R5: While armed, the trigger is high for exactly the one cycle in which a block start with valid high carries an index equal to the scheduled index. When not armed it stays low.
- R6: Firing the trigger disarms the schedule, so a later block with the same index does not fire until address 1 is written again.
- R7: A high-word write whose complete scheduled index is equal to or lower than the current index leaves the block disarmed, sets the missed flag, and issues no trigger. The current index is the one on the input when a valid block starts in that same cycle. Before any block has been seen, nothing counts as past.
- R8: While armed, a valid block start carrying an index above the scheduled index disarms the block and sets the missed flag without a trigger.
- R9: The missed flag stays set until software writes address 2 with bit 0 set. That write clears it.
- R10: A block start with valid low is ignored. It neither triggers nor changes the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sopIn | input | 1 | Start-of-block strobe |
| validIn | input | 1 | Qualifies sopIn and blkIdIn |
| blkIdIn | input | 64 | Index of the block starting now |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid the cycle after regRdEn |
| trigOut | output | 1 | One-cycle trigger aligned with the matching block start |

## Verification
The stream is driven with an ascending run of indices in which the target block arrives on schedule, a run that jumps over the scheduled index, a schedule written equal to and below the live index, and a block start with valid low that carries the scheduled index. Together these separate a correct equality match from a looser greater-or-equal test, and late arming from a skipped block. They also show whether the valid qualifier is honoured. The register reads cross a carry out of the low word between the two halves, which shows whether the high half is frozen at the low-word read or taken live.

// File: rtl/blk_evt_sched_pkg.sv
package blk_evt_sched_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic rdLo;
    logic rdHi;
    logic rdStat;
    logic rdAny;
  } ctrlStrobe_t;
endpackage

// File: rtl/blk_evt_sched_dp.sv
module blk_evt_sched_dp
  import blk_evt_sched_pkg::*;
#(
  parameter int unsigned BLK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopIn,
  input  logic              validIn,
  input  logic [BLK_W-1:0]  blkIdIn,
  input  logic [WORD_W-1:0] regWrData,
  input  ctrlStrobe_t       strobe,
  input  logic              armedSt,
  input  logic              lateSt,
  output logic              matchNow,
  output logic              passedNow,
  output logic              pastOnArm,
  output logic [WORD_W-1:0] rdData
);
  localparam int unsigned HI_W = BLK_W - WORD_W;

  logic [BLK_W-1:0]  curBlk;
  logic              haveBlk;
  logic [WORD_W-1:0] schedLo;
  logic [HI_W-1:0]   schedHi;
  logic [HI_W-1:0]   hiShadow;
  logic              blkStart;
  logic [BLK_W-1:0]  effCur;
  logic [BLK_W-1:0]  schedIdx;
  logic [BLK_W-1:0]  newSched;

  assign blkStart = sopIn && validIn;
  assign effCur   = blkStart ? blkIdIn : curBlk;
  assign schedIdx = {schedHi, schedLo};
  assign newSched = {regWrData[HI_W-1:0], schedLo};

  assign matchNow  = blkStart && (blkIdIn == schedIdx);
  assign passedNow = blkStart && (blkIdIn > schedIdx);
  assign pastOnArm = (haveBlk || blkStart) && (newSched <= effCur);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBlk  <= '0;
      haveBlk <= 1'b0;
    end else if (blkStart) begin
      curBlk  <= blkIdIn;
      haveBlk <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      schedLo <= '0;
      schedHi <= '0;
    end else begin
      if (strobe.wrLo) schedLo <= regWrData;
      if (strobe.wrHi) schedHi <= regWrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiShadow <= '0;
      rdData   <= '0;
    end else if (strobe.rdAny) begin
      if (strobe.rdLo) begin
        hiShadow <= curBlk[BLK_W-1:WORD_W];
        rdData   <= curBlk[WORD_W-1:0];
      end else if (strobe.rdHi) begin
        rdData   <= WORD_W'(hiShadow);
      end else if (strobe.rdStat) begin
        rdData   <= WORD_W'({armedSt, lateSt});
      end else begin
        rdData   <= '0;
      end
    end
  end

  assert_hold_idx_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(sopIn && validIn) |=> $stable(curBlk))
    else $error("current index changed without a valid block start");
endmodule

// File: rtl/blk_evt_sched_ctrl.sv
module blk_evt_sched_ctrl
  import blk_evt_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopIn,
  input  logic              validIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              matchNow,
  input  logic              passedNow,
  input  logic              pastOnArm,
  output ctrlStrobe_t       strobe,
  output logic              armedSt,
  output logic              lateSt,
  output logic              trigOut
);
  logic clrLate;

  always_comb begin
    strobe        = '0;
    strobe.wrLo   = regWrEn && (regAddr == ADDR_LO);
    strobe.wrHi   = regWrEn && (regAddr == ADDR_HI);
    strobe.rdLo   = regRdEn && (regAddr == ADDR_LO);
    strobe.rdHi   = regRdEn && (regAddr == ADDR_HI);
    strobe.rdStat = regRdEn && (regAddr == ADDR_STAT);
    strobe.rdAny  = regRdEn;
  end

  assign clrLate = regWrEn && (regAddr == ADDR_STAT) && regWrData[0];
  assign trigOut = armedSt && matchNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedSt <= 1'b0;
    end else if (strobe.wrHi) begin
      armedSt <= !pastOnArm;
    end else if (trigOut || (armedSt && passedNow)) begin
      armedSt <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lateSt <= 1'b0;
    end else if ((strobe.wrHi && pastOnArm) || (armedSt && passedNow && !strobe.wrHi)) begin
      lateSt <= 1'b1;
    end else if (clrLate) begin
      lateSt <= 1'b0;
    end
  end

  assert_trig_on_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (sopIn && validIn))
    else $error("trigger outside a valid block start");

  assert_disarm_after_fire_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && !strobe.wrHi) |=> !armedSt)
    else $error("still armed after firing");

  assert_arm_by_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedSt) |-> $past(strobe.wrHi))
    else $error("armed without a high-word write");

  assert_late_not_armed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHi && pastOnArm) |=> (!armedSt && lateSt))
    else $error("past schedule was armed");

  assert_late_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lateSt && !clrLate) |=> lateSt)
    else $error("missed flag dropped without a clear");
endmodule

// File: rtl/blk_evt_sched.sv
module blk_evt_sched
  import blk_evt_sched_pkg::*;
#(
  parameter int unsigned BLK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopIn,
  input  logic              validIn,
  input  logic [BLK_W-1:0]  blkIdIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              trigOut
);
  ctrlStrobe_t strobe;
  logic armedSt, lateSt, matchNow, passedNow, pastOnArm;

  blk_evt_sched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .validIn(validIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .matchNow(matchNow), .passedNow(passedNow), .pastOnArm(pastOnArm),
    .strobe(strobe), .armedSt(armedSt), .lateSt(lateSt), .trigOut(trigOut)
  );

  blk_evt_sched_dp #(.BLK_W(BLK_W)) u_dp (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .validIn(validIn), .blkIdIn(blkIdIn),
    .regWrData(regWrData), .strobe(strobe), .armedSt(armedSt), .lateSt(lateSt),
    .matchNow(matchNow), .passedNow(passedNow), .pastOnArm(pastOnArm),
    .rdData(regRdData)
  );
endmodule

// File: tb/blk_evt_sched_bench.sv
module blk_evt_sched_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sopIn = 1'b0;
  logic        validIn = 1'b0;
  logic [63:0] blkIdIn = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        trigOut;

  int total = 0;
  int bad = 0;
  bit expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  localparam logic [63:0] BASE = 64'h0000_0006_0000_0000;

  always #2.5 clk = ~clk;

  blk_evt_sched u_blk_evt_sched (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .validIn(validIn), .blkIdIn(blkIdIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .trigOut(trigOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected trigger value per valid block start
  always @(negedge clk) begin
    if (rstN && sopIn && validIn) begin
      if (expQ.size() == 0) begin
        check("R5 unexpected block", 1, 0);
      end else begin
        check(tagQ.pop_front(), {63'd0, trigOut}, {63'd0, expQ.pop_front()});
      end
    end
  end

  task automatic sendBlock(input logic [63:0] id, input bit expTrig, input string req);
    expQ.push_back(expTrig);
    tagQ.push_back(req);
    @(posedge clk); #1;
    sopIn = 1'b1; validIn = 1'b1; blkIdIn = id;
    @(posedge clk); #1;
    sopIn = 1'b0; validIn = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic schedule(input logic [63:0] id);
    wrReg(2'd0, id[31:0]);
    wrReg(2'd1, id[63:32]);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 trig", {63'd0, trigOut}, 0);
    check("R1 rdData", {32'd0, regRdData}, 0);
    rdReg(2'd2, d); check("R1 status", {32'd0, d}, 0);

    for (int i = 100; i < 103; i++) sendBlock(64'(i), 0, "R5 unarmed");
    rdReg(2'd0, d); check("R2 low", {32'd0, d}, 102);
    rdReg(2'd1, d); check("R3 high", {32'd0, d}, 0);

    sendBlock(64'h0000_0005_FFFF_FFFE, 0, "R5 unarmed");
    rdReg(2'd0, d); check("R2 low near carry", {32'd0, d}, 64'hFFFF_FFFE);
    sendBlock(64'h0000_0005_FFFF_FFFF, 0, "R5 unarmed");
    sendBlock(BASE, 0, "R5 unarmed");
    rdReg(2'd1, d); check("R3 frozen high", {32'd0, d}, 5);
    rdReg(2'd0, d); check("R2 low after carry", {32'd0, d}, 0);
    rdReg(2'd1, d); check("R3 high after carry", {32'd0, d}, 6);

    wrReg(2'd0, 32'd3);
    rdReg(2'd2, d); check("R4 low write no arm", {32'd0, d}, 0);
    wrReg(2'd1, 32'd6);
    rdReg(2'd2, d); check("R4 armed", {32'd0, d}, 2);
    sendBlock(BASE + 1, 0, "R5 before");
    sendBlock(BASE + 2, 0, "R5 before");
    sendBlock(BASE + 3, 1, "R5 fire");
    rdReg(2'd2, d); check("R6 disarmed", {32'd0, d}, 0);
    sendBlock(BASE + 3, 0, "R6 no refire");
    sendBlock(BASE + 4, 0, "R6 next");

    schedule(BASE + 4);
    rdReg(2'd2, d); check("R7 equal is late", {32'd0, d}, 1);
    sendBlock(BASE + 4, 0, "R7 no fire");
    sendBlock(BASE + 5, 0, "R7 no fire");
    schedule(BASE + 2);
    rdReg(2'd2, d); check("R9 still set", {32'd0, d}, 1);
    wrReg(2'd2, 32'd0);
    rdReg(2'd2, d); check("R9 bit0 clear needed", {32'd0, d}, 1);
    wrReg(2'd2, 32'd1);
    rdReg(2'd2, d); check("R9 cleared", {32'd0, d}, 0);

    schedule(BASE + 8);
    rdReg(2'd2, d); check("R8 armed", {32'd0, d}, 2);
    sendBlock(BASE + 9, 0, "R8 skip");
    rdReg(2'd2, d); check("R8 missed", {32'd0, d}, 1);
    sendBlock(BASE + 8, 0, "R8 no late fire");
    wrReg(2'd2, 32'd1);

    schedule(BASE + 12);
    @(posedge clk); #1;
    sopIn = 1'b1; validIn = 1'b0; blkIdIn = BASE + 12;
    @(negedge clk);
    check("R10 invalid start no trig", {63'd0, trigOut}, 0);
    @(posedge clk); #1;
    sopIn = 1'b0;
    rdReg(2'd0, d); check("R10 index unchanged", {32'd0, d}, 8);
    sendBlock(BASE + 12, 1, "R10 valid fires");
    rdReg(2'd0, d); check("R2 low updated", {32'd0, d}, 12);

    repeat (3) @(posedge clk);
    check("R5 queue drained", 64'(expQ.size()), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule